// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block is a watchdog built on a 12-bit down-counter. A power-of-two prescaler, selected by a 3-bit code, turns the system clock into counter ticks. Software drives the block through a small write/read strobe port with four addresses: a key address, a prescaler address, a reload address and a window address. It does not use plain enable bits. Magic 16-bit values written to the key address start the watchdog, refresh the counter, and open or close write access to the three configuration registers.

The block raises a one-cycle reset request in two cases. The first is a timeout: the counter runs down to zero. The second is a refresh that comes too early, while the counter is still above the window value and the window check is enabled. A window value of all ones turns the window check off. Once started, the watchdog stays running until a system reset.

Top module: `wdg_top`

## Requirements
- R1: After reset the watchdog is idle (`running`=0, `bite`=0). The counter reads 0xFFF, reload 0xFFF, window 0xFFF and prescaler code 0, and configuration writes are locked.
- R2: Writes to address 1 (prescaler, bits 2:0), address 2 (reload, bits 11:0) and address 3 (window, bits 11:0) take effect only after key 0x5555 has been written to address 0. Key 0x0000 locks them again, and writes made while locked leave the registers unchanged.
- R3: A write to address 0 with any value other than 0x5555, 0x0000, 0xAAAA or 0xCCCC has no effect. In particular it does not start the watchdog.
- R4: Key 0xAAAA reloads the counter from the reload register and locks the configuration registers.
- R5: Key 0xCCCC starts an idle watchdog and loads the counter from the reload register. The counter then falls by one per prescaler tick. On the tick that finds it at 1 (or 0), `bite` is high for one cycle and the counter reloads, so a timeout comes divide×reload cycles after the start or refresh edge.
- R6: The window check applies when the window is not 0xFFF. A refresh while running with the counter above the window raises `bite` for one cycle and does not reload the counter.
- R7: Prescaler codes 0 to 6 divide by 4, 8, 16, 32, 64, 128 and 256. Code 7 divides by 256.
- R8: Once running, no key write stops the watchdog. Only reset returns it to idle.
- R9: With the window at 0xFFF, a refresh at any counter value reloads the counter and raises no `bite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 prescaler, 2 reload, 3 window |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address: 0 counter, 1 prescaler, 2 reload, 3 window |
| rd_data | output | 16 | Read data, combinational, zero-extended |
| running | output | 1 | Watchdog has been started |
| bite | output | 1 | One-cycle reset request |

## Verification
The hardest case to reach from the ports is the early-refresh fault. It needs the block unlocked, a window below the reload value, a started counter, and then a refresh on an exact edge while the counter is still above the window. The driver counts clock edges from the start write and issues refreshes on chosen edges: one early refresh, which must bite without reloading, as the counter read back a few cycles later shows, and one late refresh, which must reload. Each reset request is predicted by edge number and queued before the stimulus that causes it, so a bite that comes early, late or without cause is caught.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int WDG_CNT_W = 12;
    localparam int WDG_KEY_W = 16;
    localparam int WDG_PSC_W = 3;
    localparam int WDG_DIV_W = 8;

    localparam logic [WDG_KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [WDG_KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [WDG_KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [WDG_KEY_W-1:0] KEY_LOCK    = 16'h0000;

    localparam logic [1:0] ADR_KEY  = 2'd0;
    localparam logic [1:0] ADR_PSC  = 2'd1;
    localparam logic [1:0] ADR_RLD  = 2'd2;
    localparam logic [1:0] ADR_WIN  = 2'd3;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_START,
        ACT_REFRESH,
        ACT_UNLOCK,
        ACT_LOCK
    } key_act_e;

    typedef struct packed {
        logic [WDG_PSC_W-1:0] psc;
        logic [WDG_CNT_W-1:0] reload;
        logic [WDG_CNT_W-1:0] window;
    } wdg_cfg_t;

    // Terminal count of the prescaler counter: divide is 4 << code, code 7 clamps to 256.
    function automatic logic [WDG_DIV_W-1:0] psc_limit(input logic [WDG_PSC_W-1:0] code);
        logic [WDG_PSC_W-1:0] c;
        logic [WDG_DIV_W:0]   d;
        c = (code > 3'd6) ? 3'd6 : code;
        d = 9'd4 << c;
        return WDG_DIV_W'(d - 9'd1);
    endfunction
endpackage

// File: rtl/wdg_keydec.sv
module wdg_keydec
    import wdg_pkg::*;
(
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [WDG_KEY_W-1:0] wr_data,
    output key_act_e             act
);
    always_comb begin
        act = ACT_NONE;
        if (wr_en && wr_addr == ADR_KEY) begin
            case (wr_data)
                KEY_START:   act = ACT_START;
                KEY_REFRESH: act = ACT_REFRESH;
                KEY_UNLOCK:  act = ACT_UNLOCK;
                KEY_LOCK:    act = ACT_LOCK;
                default:     act = ACT_NONE;
            endcase
        end
    end
endmodule

// File: rtl/wdg_cfg.sv
module wdg_cfg
    import wdg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  key_act_e             act,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [WDG_KEY_W-1:0] wr_data,
    output wdg_cfg_t             cfg,
    output logic                 unlocked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked   <= 1'b0;
            cfg.psc    <= '0;
            cfg.reload <= '1;
            cfg.window <= '1;
        end else begin
            if (act == ACT_UNLOCK) begin
                unlocked <= 1'b1;
            end else if (act == ACT_LOCK || act == ACT_REFRESH) begin
                unlocked <= 1'b0;
            end
            if (wr_en && unlocked) begin
                case (wr_addr)
                    ADR_PSC: cfg.psc    <= wr_data[WDG_PSC_W-1:0];
                    ADR_RLD: cfg.reload <= wr_data[WDG_CNT_W-1:0];
                    ADR_WIN: cfg.window <= wr_data[WDG_CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale
    import wdg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic                 clr,
    input  logic [WDG_PSC_W-1:0] code,
    output logic                 tick
);
    logic [WDG_DIV_W-1:0] pcnt;

    assign tick = run && (pcnt >= psc_limit(code));

    always_ff @(posedge clk) begin
        if (rst || clr || !run || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdg_core.sv
module wdg_core
    import wdg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  key_act_e             act,
    input  logic                 tick,
    input  wdg_cfg_t             cfg,
    output logic [WDG_CNT_W-1:0] cnt,
    output logic                 running,
    output logic                 bite,
    output logic                 psc_clr
);
    logic win_on, early, start_ev, reload_ev;

    assign win_on    = (cfg.window != '1);
    assign start_ev  = (act == ACT_START) && !running;
    assign early     = running && (act == ACT_REFRESH) && win_on && (cnt > cfg.window);
    assign reload_ev = start_ev || ((act == ACT_REFRESH) && !early);
    assign psc_clr   = reload_ev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '1;
            running <= 1'b0;
            bite    <= 1'b0;
        end else begin
            bite <= early;
            if (start_ev) begin
                running <= 1'b1;
            end
            if (reload_ev) begin
                cnt <= cfg.reload;
            end else if (running && tick) begin
                if (cnt <= WDG_CNT_W'(1)) begin
                    bite <= 1'b1;
                    cnt  <= cfg.reload;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wdg_top.sv
module wdg_top
    import wdg_pkg::*;
#(
    parameter int DATA_W = WDG_KEY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              running,
    output logic              bite
);
    key_act_e             act;
    wdg_cfg_t             cfg;
    logic                 unlocked;
    logic                 tick;
    logic                 psc_clr;
    logic [WDG_CNT_W-1:0] cnt_q;

    wdg_keydec u_key (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .act     (act)
    );

    wdg_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cfg      (cfg),
        .unlocked (unlocked)
    );

    wdg_prescale u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (running),
        .clr  (psc_clr),
        .code (cfg.psc),
        .tick (tick)
    );

    wdg_core u_core (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .tick    (tick),
        .cfg     (cfg),
        .cnt     (cnt_q),
        .running (running),
        .bite    (bite),
        .psc_clr (psc_clr)
    );

    always_comb begin
        case (rd_addr)
            ADR_KEY: rd_data = DATA_W'(cnt_q);
            ADR_PSC: rd_data = DATA_W'(cfg.psc);
            ADR_RLD: rd_data = DATA_W'(cfg.reload);
            default: rd_data = DATA_W'(cfg.window);
        endcase
    end
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker
    import wdg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 running,
    input logic                 bite,
    input logic                 unlocked,
    input logic [WDG_CNT_W-1:0] cnt,
    input logic [WDG_CNT_W-1:0] reload,
    input logic [WDG_CNT_W-1:0] window,
    input logic [WDG_PSC_W-1:0] psc,
    input logic                 wr_en,
    input logic [1:0]           wr_addr,
    input logic [WDG_KEY_W-1:0] wr_data
);
    p_run_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        running |=> running);

    p_bite_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
        bite |-> running);

    p_cnt_step_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ((cnt == $past(cnt) - 1'b1) || (cnt == $past(reload))));

    p_locked_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> ($stable(reload) && $stable(window) && $stable(psc)));

    p_bad_key_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADR_KEY && !running && wr_data != KEY_START) |=> !running);
endmodule

bind wdg_top wdg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .running  (running),
    .bite     (bite),
    .unlocked (unlocked),
    .cnt      (cnt_q),
    .reload   (cfg.reload),
    .window   (cfg.window),
    .psc      (cfg.psc),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
);

// File: tb/sim_wdg_top.sv
module sim_wdg_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        running, bite;

    int cyc = 0;
    int errors = 0;
    int checks = 0;

    typedef struct {
        int    at;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdg_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .running(running), .bite(bite)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic push(input int at, input string tag);
        exp_t e;
        e.at = at;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: every bite must match the next predicted edge.
    always @(negedge clk) begin
        if (!rst && bite) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected bite: got cycle %0d expected none", cyc);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.at != cyc) begin
                    errors++;
                    $display("FAIL %s bite: got cycle %0d expected %0d", e.tag, cyc, e.at);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d, output int at);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        at = cyc;
    endtask

    task automatic wr_at(input int n, input logic [1:0] a, input logic [15:0] d);
        do @(negedge clk); while (cyc != n - 1);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pending_empty(input string tag);
        chk({tag, " pending bites"}, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic timeout_case(input logic [2:0] code, input int rld, input string tag);
        int s, div;
        do_reset();
        wr(2'd0, 16'h5555, s);
        wr(2'd1, {13'd0, code}, s);
        wr(2'd2, 16'(rld), s);
        wr(2'd0, 16'hCCCC, s);
        div = (code >= 3'd6) ? 256 : (4 << code);
        push(s + div * rld, tag);
        wait_cyc(s + div * rld + 4);
        pending_empty(tag);
    endtask

    initial begin
        #(50000 * 8);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int v, s;
        do_reset();
        // R1 reset state
        chk("R1 running", running, 0);
        chk("R1 bite", bite, 0);
        rd(2'd0, v); chk("R1 counter", v, 'hFFF);
        rd(2'd1, v); chk("R1 prescaler", v, 0);
        rd(2'd2, v); chk("R1 reload", v, 'hFFF);
        rd(2'd3, v); chk("R1 window", v, 'hFFF);

        // R2 locked write ignored
        wr(2'd2, 16'd5, s);
        rd(2'd2, v); chk("R2 locked reload write", v, 'hFFF);
        // R3 unknown key
        wr(2'd0, 16'h1234, s);
        chk("R3 unknown key no start", running, 0);
        rd(2'd0, v); chk("R3 unknown key counter", v, 'hFFF);
        // R2 unlock then write
        wr(2'd0, 16'h5555, s);
        wr(2'd2, 16'd5, s);
        rd(2'd2, v); chk("R2 unlocked reload write", v, 5);
        wr(2'd0, 16'h0000, s);
        wr(2'd2, 16'd9, s);
        rd(2'd2, v); chk("R2 relocked reload write", v, 5);
        // R4 refresh relocks and reloads counter while idle
        wr(2'd0, 16'h5555, s);
        wr(2'd0, 16'hAAAA, s);
        rd(2'd0, v); chk("R4 refresh loads counter", v, 5);
        wr(2'd2, 16'd7, s);
        rd(2'd2, v); chk("R4 refresh relocks", v, 5);

        // R5 start and timeout with divide 4, reload 5
        wr(2'd0, 16'hCCCC, s);
        chk("R5 running after start", running, 1);
        rd(2'd0, v); chk("R5 counter loaded", v, 5);
        push(s + 20, "R5");
        push(s + 50, "R4");
        // R9: window 0xFFF, refresh at any count is accepted
        wr_at(s + 30, 2'd0, 16'hAAAA);
        rd(2'd0, v); chk("R9 refresh reload", v, 5);
        // R8 no key stops it
        wr(2'd0, 16'h0000, v);
        wr(2'd0, 16'h5555, v);
        wr(2'd0, 16'h0000, v);
        wr(2'd0, 16'hCCCC, v);
        chk("R8 still running", running, 1);
        wait_cyc(s + 55);
        pending_empty("R5");

        // R6 window: reload 20, window 10
        do_reset();
        wr(2'd0, 16'h5555, s);
        wr(2'd2, 16'd20, s);
        wr(2'd3, 16'd10, s);
        wr(2'd0, 16'hCCCC, s);
        push(s + 5, "R6 early");
        wr_at(s + 5, 2'd0, 16'hAAAA);
        wait_cyc(s + 9);
        rd(2'd0, v); chk("R6 early refresh no reload", v, 18);
        push(s + 130, "R6 late refresh");
        wr_at(s + 50, 2'd0, 16'hAAAA);
        wait_cyc(s + 135);
        pending_empty("R6");

        // R7 prescaler codes
        timeout_case(3'd2, 3, "R7 code2");
        timeout_case(3'd6, 2, "R7 code6");
        timeout_case(3'd7, 2, "R7 code7");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule